// File: doc/BRIEF.md
# Programmable Flag Pin Unit with Dual Interrupt Requests

This block manages sixteen general-purpose flag pins. Each pin can act as an output that drives a software-owned flag bit. It can also act as an input whose active level, or chosen edges, latch into that flag bit. A small word-addressed register bus configures the block. Per-pin settings cover direction, polarity, level or edge sensitivity, and a both-edges option.

Flag bits and the two interrupt mask sets are never written directly. Software changes them through paired addresses: writing a 1 to a set address sets the bit, and writing a 1 to a clear address clears it. A zero bit in either write has no effect. Two registered interrupt request outputs each report whether any flag bit is pending while its own mask is enabled. This lets each pin be routed to one or both interrupt priority levels.

Input pins pass through a two-stage synchroniser before any detection. In edge mode, a detected edge latches its flag until software clears it, so a pulse lasting a single clock cycle is still seen. Software can set the flag of an input pin to raise that pin's interrupt without any activity on the pin.

Top module: `pf_flag_unit`

## Requirements
- R1: After reset every configuration register reads zero, pin_oe_o and pin_out_o are zero, and both interrupt outputs are low. Addresses 0xE and 0xF always read zero.
- R2: The direction register is written and read at address 0x0 and its alias 0x1. Bit n equal to 1 makes pin n an output, and pin_oe_o equals the direction register.
- R3: A write to address 0x3 sets the flags whose data bits are 1, and a write to 0x2 clears them. Zero bits leave flags unchanged. Both addresses read back the current flag vector, and pin_out_o equals the flag vector.
- R4: On an input pin in edge mode, a software set of its flag latches the flag and raises every interrupt output whose mask enables that pin.
- R5: Mask A is set through 0x5 and cleared through 0x4. Mask B is set through 0x7 and cleared through 0x6. Zero bits have no effect. Both addresses of a pair read back that mask.
- R6: In level mode (sensitivity bit 0), an input pin's flag equals its synchronised pin level XOR its polarity bit. The flag changes three clock edges after the pin changes.
- R7: In edge mode (sensitivity bit 1) with both-edges bit 0, a rising edge is detected when the polarity bit is 0 and a falling edge when it is 1. The opposite edge is ignored. A detected edge latches the flag until it is cleared, and a one-cycle pulse is captured.
- R8: With sensitivity bit 1 and both-edges bit 1, both edges latch the flag whatever the polarity bit is.
- R9: irq_a_o is the OR over all pins of (flag AND mask A), registered one cycle. irq_b_o is formed the same way from mask B, and the two are independent.
- R10: The polarity register is at 0x8/0x9, the sensitivity register at 0xA/0xB and the both-edges register at 0xC/0xD. Each is written at either address and read back at both.
- R11: On an output pin, polarity and pin_in_i have no effect. The flag changes only through the set and clear addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Write strobe for bus_addr_i |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 16 | Write data, bit n for pin n |
| bus_rdata_o | output | 16 | Combinational readback of bus_addr_i |
| pin_in_i | input | 16 | Asynchronous pin inputs |
| pin_out_o | output | 16 | Output value, the flag vector |
| pin_oe_o | output | 16 | Output enable, the direction register |
| irq_a_o | output | 1 | Interrupt request, priority A |
| irq_b_o | output | 1 | Interrupt request, priority B |

## Verification
Each pin in turn receives a walking one-cycle pulse. This shows that single-edge detection latches a pulse too short for level mode to hold, and it shows the rising and falling cases as polarity changes. Multi-bit patterns that rise on some pins and fall on others at once separate the both-edges mode from the single-edge mode. A falling step under active-high polarity proves that the wrong edge is ignored. Walking flag bits against interleaved A and B masks tell the two interrupt paths apart, and software sets on quiet input pins isolate the software trigger from real pin activity.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;
    localparam int ADDR_W = 4;

    // Address bits [3:1] select a register pair; bit 0 picks set (1) or clear (0)
    typedef enum logic [2:0] {
        GRP_DIR   = 3'd0,
        GRP_FLAG  = 3'd1,
        GRP_MASKA = 3'd2,
        GRP_MASKB = 3'd3,
        GRP_POL   = 3'd4,
        GRP_SENS  = 3'd5,
        GRP_BOTH  = 3'd6,
        GRP_NONE  = 3'd7
    } reg_grp_e;
endpackage

// File: rtl/pf_sync.sv
`timescale 1ns/1ps
module pf_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/pf_edge_detect.sv
`timescale 1ns/1ps
module pf_edge_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] both_i,
    output logic [W-1:0] active_o,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sync_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall;
        assign rise        = sync_i[i] & ~prev_q[i];
        assign fall        = ~sync_i[i] & prev_q[i];
        assign hit_o[i]    = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
        assign active_o[i] = sync_i[i] ^ pol_i[i];
    end
endmodule

// File: rtl/pf_flag_unit.sv
`timescale 1ns/1ps
module pf_flag_unit
    import pf_pkg::*;
#(
    parameter int N_PINS      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [N_PINS-1:0] bus_wdata_i,
    output logic [N_PINS-1:0] bus_rdata_o,
    input  logic [N_PINS-1:0] pin_in_i,
    output logic [N_PINS-1:0] pin_out_o,
    output logic [N_PINS-1:0] pin_oe_o,
    output logic              irq_a_o,
    output logic              irq_b_o
);
    typedef struct packed {
        logic [N_PINS-1:0] dir;
        logic [N_PINS-1:0] flag;
        logic [N_PINS-1:0] mska;
        logic [N_PINS-1:0] mskb;
        logic [N_PINS-1:0] pol;
        logic [N_PINS-1:0] sens;
        logic [N_PINS-1:0] both;
        logic              irq_a;
        logic              irq_b;
    } state_t;

    state_t cur_q, nxt_d;

    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] lvl_active;
    logic [N_PINS-1:0] edge_hit;

    pf_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (pin_in_i),
        .dout_o (pin_sync)
    );

    pf_edge_detect #(.W(N_PINS)) det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pin_sync),
        .pol_i    (cur_q.pol),
        .both_i   (cur_q.both),
        .active_o (lvl_active),
        .hit_o    (edge_hit)
    );

    reg_grp_e grp;
    logic     hi_addr;
    assign grp     = reg_grp_e'(bus_addr_i[ADDR_W-1:1]);
    assign hi_addr = bus_addr_i[0];

    logic [N_PINS-1:0] flag_set, flag_clr, ma_set, ma_clr, mb_set, mb_clr;

    always_comb begin
        nxt_d    = cur_q;
        flag_set = '0;
        flag_clr = '0;
        ma_set   = '0;
        ma_clr   = '0;
        mb_set   = '0;
        mb_clr   = '0;

        if (bus_wr_i) begin
            case (grp)
                GRP_DIR:   nxt_d.dir  = bus_wdata_i;
                GRP_FLAG:  if (hi_addr) flag_set = bus_wdata_i; else flag_clr = bus_wdata_i;
                GRP_MASKA: if (hi_addr) ma_set   = bus_wdata_i; else ma_clr   = bus_wdata_i;
                GRP_MASKB: if (hi_addr) mb_set   = bus_wdata_i; else mb_clr   = bus_wdata_i;
                GRP_POL:   nxt_d.pol  = bus_wdata_i;
                GRP_SENS:  nxt_d.sens = bus_wdata_i;
                GRP_BOTH:  nxt_d.both = bus_wdata_i;
                default:   ;
            endcase
        end

        nxt_d.mska = (cur_q.mska & ~ma_clr) | ma_set;
        nxt_d.mskb = (cur_q.mskb & ~mb_clr) | mb_set;

        for (int i = 0; i < N_PINS; i++) begin
            if (cur_q.dir[i]) begin
                // output pin: software owned
                nxt_d.flag[i] = (cur_q.flag[i] & ~flag_clr[i]) | flag_set[i];
            end else if (cur_q.sens[i]) begin
                // edge mode: sticky, a detected edge wins over a clear
                nxt_d.flag[i] = (cur_q.flag[i] & ~flag_clr[i]) | flag_set[i] | edge_hit[i];
            end else if (flag_set[i]) begin
                nxt_d.flag[i] = 1'b1;
            end else if (flag_clr[i]) begin
                nxt_d.flag[i] = 1'b0;
            end else begin
                nxt_d.flag[i] = lvl_active[i];
            end
        end

        nxt_d.irq_a = |(cur_q.flag & cur_q.mska);
        nxt_d.irq_b = |(cur_q.flag & cur_q.mskb);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        case (grp)
            GRP_DIR:   bus_rdata_o = cur_q.dir;
            GRP_FLAG:  bus_rdata_o = cur_q.flag;
            GRP_MASKA: bus_rdata_o = cur_q.mska;
            GRP_MASKB: bus_rdata_o = cur_q.mskb;
            GRP_POL:   bus_rdata_o = cur_q.pol;
            GRP_SENS:  bus_rdata_o = cur_q.sens;
            GRP_BOTH:  bus_rdata_o = cur_q.both;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign pin_out_o = cur_q.flag;
    assign pin_oe_o  = cur_q.dir;
    assign irq_a_o   = cur_q.irq_a;
    assign irq_b_o   = cur_q.irq_b;
endmodule

// File: rtl/pf_flag_unit_chk.sv
`timescale 1ns/1ps
module pf_flag_unit_chk #(
    parameter int N_PINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [3:0]        bus_addr_i,
    input logic [N_PINS-1:0] bus_wdata_i,
    input logic [N_PINS-1:0] pin_out_i,
    input logic [N_PINS-1:0] pin_oe_i,
    input logic [N_PINS-1:0] mska_i,
    input logic [N_PINS-1:0] mskb_i,
    input logic              irq_a_i,
    input logic              irq_b_i
);
    assert_irq_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a_i == (|($past(pin_out_i & mska_i))));

    assert_irq_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b_i == (|($past(pin_out_i & mskb_i))));

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 4'h3) |=> ((pin_out_i & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    assert_flag_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 4'h2) |=> ((pin_out_i & $past(bus_wdata_i & pin_oe_i)) == '0));

    assert_mask_a_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 4'h5) |=> ((mska_i & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    assert_mask_b_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 4'h6) |=> ((mskb_i & $past(bus_wdata_i)) == '0));

    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i[3:1] == 3'd0) |=> $stable(pin_oe_i));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i[3:1] == 3'd1) |=> (((pin_out_i ^ $past(pin_out_i)) & $past(pin_oe_i)) == '0));
endmodule

bind pf_flag_unit pf_flag_unit_chk #(.N_PINS(N_PINS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pin_out_i   (pin_out_o),
    .pin_oe_i    (pin_oe_o),
    .mska_i      (cur_q.mska),
    .mskb_i      (cur_q.mskb),
    .irq_a_i     (irq_a_o),
    .irq_b_i     (irq_b_o)
);

// File: tb/pf_flag_unit_tb.sv
`timescale 1ns/1ps
module pf_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pf_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pin_in_i(pin_in),
        .pin_out_o(pin_out), .pin_oe_o(pin_oe), .irq_a_o(irq_a), .irq_b_o(irq_b)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic drive(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 16; a++) rd_chk("R1 reset readback", 4'(a), 16'h0000);
        chk("R1 oe", pin_oe, 16'h0); chk("R1 out", pin_out, 16'h0);
        chk("R1 irq", {14'd0, irq_a, irq_b}, 16'h0);

        // R2: direction and alias
        wr(4'h0, 16'hA5A5);
        rd_chk("R2 dir", 4'h0, 16'hA5A5); rd_chk("R2 dir alias", 4'h1, 16'hA5A5);
        chk("R2 oe", pin_oe, 16'hA5A5);
        wr(4'h1, 16'h00FF);
        rd_chk("R2 dir via alias", 4'h0, 16'h00FF);

        // R3 / R11: flags on output pins
        wr(4'h0, 16'hFFFF);
        drive(16'h5A3C);
        wr(4'h3, 16'h1234);
        chk("R3 set out", pin_out, 16'h1234);
        rd_chk("R3 read clr addr", 4'h2, 16'h1234); rd_chk("R3 read set addr", 4'h3, 16'h1234);
        wr(4'h3, 16'h0000);
        chk("R3 zero set", pin_out, 16'h1234);
        wr(4'h2, 16'h0204);
        chk("R3 clear", pin_out, 16'h1030);
        wr(4'h2, 16'h0000);
        chk("R3 zero clear", pin_out, 16'h1030);
        wr(4'h8, 16'hFFFF);
        for (int k = 0; k < 6; k++) begin
            drive(16'(k * 16'h2F1B));
            idle(3);
            chk("R11 output pin unaffected", pin_out, 16'h1030);
        end
        wr(4'h8, 16'h0000);
        wr(4'h2, 16'hFFFF);
        chk("R3 clear all", pin_out, 16'h0);

        // R5: masks
        wr(4'h5, 16'hF0F0); wr(4'h4, 16'h3030);
        rd_chk("R5 mask A", 4'h4, 16'hC0C0); rd_chk("R5 mask A alias", 4'h5, 16'hC0C0);
        wr(4'h7, 16'h0F0F); wr(4'h6, 16'h0000); wr(4'h6, 16'h0102);
        rd_chk("R5 mask B", 4'h6, 16'h0E0D); rd_chk("R5 mask B alias", 4'h7, 16'h0E0D);
        rd_chk("R5 mask A untouched by B", 4'h4, 16'hC0C0);
        wr(4'h4, 16'hFFFF); wr(4'h6, 16'hFFFF);

        // R9: walking flag against interleaved masks
        wr(4'h5, 16'h5555); wr(4'h7, 16'hAAAA);
        for (int i = 0; i < 16; i++) begin
            wr(4'h3, 16'(1 << i));
            idle(1);
            chk("R9 irq_a", {15'd0, irq_a}, 16'((i % 2) == 0));
            chk("R9 irq_b", {15'd0, irq_b}, 16'((i % 2) == 1));
            wr(4'h2, 16'hFFFF);
            idle(1);
            chk("R9 irq idle", {14'd0, irq_a, irq_b}, 16'h0);
        end
        wr(4'h4, 16'hFFFF); wr(4'h6, 16'hFFFF);

        // R6: level mode on inputs
        wr(4'h0, 16'h0000);
        drive(16'h0000); idle(4);
        for (int i = 0; i < 16; i++) begin
            drive(16'(1 << i)); idle(4);
            rd_chk("R6 level high", 4'h2, 16'(1 << i));
        end
        drive(16'h0000); idle(4);
        rd_chk("R6 level released", 4'h2, 16'h0000);
        wr(4'h8, 16'hFFFF);
        drive(16'hFFFF); idle(4);
        rd_chk("R6 active low idle", 4'h2, 16'h0000);
        drive(16'hFFF7); idle(4);
        rd_chk("R6 active low asserted", 4'h2, 16'h0008);

        // R7: single-edge mode, active high
        wr(4'h8, 16'h0000);
        drive(16'h0000); idle(4);
        wr(4'hA, 16'hFFFF);
        wr(4'h2, 16'hFFFF); idle(2);
        rd_chk("R7 quiet", 4'h2, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            drive(16'(1 << i)); drive(16'h0000); idle(4);
            rd_chk("R7 narrow rising pulse latched", 4'h2, 16'(1 << i));
            idle(3);
            rd_chk("R7 flag held", 4'h2, 16'(1 << i));
            wr(4'h2, 16'(1 << i));
            rd_chk("R7 cleared", 4'h2, 16'h0000);
        end
        drive(16'hFFFF); idle(4);
        rd_chk("R7 rising all", 4'h2, 16'hFFFF);
        wr(4'h2, 16'hFFFF);
        drive(16'h0000); idle(4);
        rd_chk("R7 falling ignored when active high", 4'h2, 16'h0000);
        drive(16'hFFFF); idle(4);
        wr(4'h2, 16'hFFFF);
        // active low: falling edges
        wr(4'h8, 16'hFFFF); idle(2);
        rd_chk("R7 polarity change no event", 4'h2, 16'h0000);
        for (int i = 0; i < 16; i++) begin
            drive(~16'(1 << i)); drive(16'hFFFF); idle(4);
            rd_chk("R7 narrow low pulse latched", 4'h2, 16'(1 << i));
            wr(4'h2, 16'hFFFF);
        end

        // R8: both edges
        wr(4'hC, 16'hFFFF);
        wr(4'h8, 16'h0000);
        wr(4'h2, 16'hFFFF);
        drive(16'h00FF); idle(4);
        rd_chk("R8 falls on high byte", 4'h2, 16'hFF00);
        wr(4'h2, 16'hFFFF);
        drive(16'h0F0F); idle(4);
        rd_chk("R8 mixed rise and fall", 4'h2, 16'h0FF0);
        wr(4'h2, 16'hFFFF);
        wr(4'h8, 16'hFFFF);
        drive(16'hF00F); idle(4);
        rd_chk("R8 both edges ignore polarity", 4'h2, 16'hFF00);
        wr(4'h2, 16'hFFFF);
        wr(4'hC, 16'h0000);

        // R4: software trigger on quiet input pins
        for (int i = 0; i < 16; i++) begin
            wr(4'h5, 16'(1 << i));
            wr(4'h3, 16'(1 << i));
            idle(3);
            rd_chk("R4 soft flag latched", 4'h2, 16'(1 << i));
            chk("R4 irq_a raised", {14'd0, irq_a, irq_b}, 16'h2);
            wr(4'h2, 16'hFFFF);
            wr(4'h4, 16'hFFFF);
            idle(1);
            chk("R4 irq_a dropped", {14'd0, irq_a, irq_b}, 16'h0);
        end

        // R10: configuration aliases
        wr(4'h9, 16'h1357); rd_chk("R10 pol", 4'h8, 16'h1357); rd_chk("R10 pol alias", 4'h9, 16'h1357);
        wr(4'hB, 16'h2468); rd_chk("R10 sens", 4'hA, 16'h2468);
        wr(4'hD, 16'h9ABC); rd_chk("R10 both", 4'hC, 16'h9ABC); rd_chk("R10 both alias", 4'hD, 16'h9ABC);
        wr(4'hE, 16'hFFFF); rd_chk("R1 unused reads zero", 4'hE, 16'h0000);
        rd_chk("R1 unused alias reads zero", 4'hF, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule